// File: doc/BRIEF.md
# Clock Source Selection Controller

This block chooses which of three oscillators drives the system clock: a primary oscillator, a low-frequency secondary oscillator run by a timer, or an on-chip internal oscillator. Software writes an 8-bit control/status register. The register holds a two-bit select code, an idle-enable bit and a read-only status bit. A configuration input sets which source the all-zero select code stands for. A request for the secondary source is dropped unless that oscillator is enabled.

A new selection does not take effect at once. The block holds the old source and waits until the target oscillator's stable flag has stayed high for a set number of consecutive cycles. Only then does it move the active source and update the status outputs. A write made during a pending handover restarts the wait with the new target. Outputs report the active source one-hot, whether a handover is pending, and whether the secondary oscillator is the one in use. A separate sleep request input is turned into a one-cycle idle or sleep indication, chosen by the idle-enable bit.

Top module: `clk_src_ctrl`

## Requirements
- R1: Select code 2'b11 targets the internal oscillator, 2'b10 the primary oscillator and 2'b01 the secondary oscillator. `active_src` is one-hot with bit 0 = primary, bit 1 = secondary and bit 2 = internal.
- R2: Select code 2'b00 targets the primary oscillator when `cfg_pri_default` is 1 and the internal oscillator when it is 0.
- R3: A write whose bits [1:0] are 2'b01 while `sec_osc_en` is low leaves the select field, the active source and `busy` unchanged. Bit 7 of that write is still stored.
- R4: `rd_data` bit 7 is idle enable, bit 3 is the status bit and bits [1:0] are the select field. Bits 6:4 and 2 always read 0. Writes change only bits 7 and 1:0.
- R5: The reset is synchronous and active high. After reset the idle enable and select field are 0 and the status bit equals the inverse of `cfg_two_speed`. With `cfg_two_speed` at 0, the source for code 00 is active straight out of reset. With it at 1, the internal oscillator is active and a handover to the code-00 source is pending.
- R6: A write that changes the select code, or any accepted select write while `busy` is high, raises `busy` at the write edge. When the target stays stable, `active_src` changes at the SETTLE_CYCLES-th rising edge after the write edge, and `busy` falls on that same edge. A write that repeats the current code with `busy` low starts nothing.
- R7: Each cycle in which the target's stable flag is low restarts the count. `active_src` holds its old value until SETTLE_CYCLES consecutive stable cycles have passed.
- R8: An accepted select write during a pending handover replaces the target and restarts the full count.
- R9: At the completion of a handover, the status bit becomes 1 if the handover was started by code 00 and 0 if it was started by code 01, 10 or 11.
- R10: `sec_run` is high exactly when the secondary oscillator is the active source, and it is never high together with the status bit.
- R11: On a cycle with `sleep_req` high, the next cycle shows a one-cycle `enter_idle` pulse if idle enable is 1, or a one-cycle `enter_sleep` pulse if it is 0. The two are never high together.
- R12: `active_src` always has exactly one bit set, and it changes only on the edge where `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| sec_osc_en | input | 1 | Secondary oscillator enabled |
| cfg_pri_default | input | 1 | 1: code 00 means primary; 0: code 00 means internal |
| cfg_two_speed | input | 1 | Start on the internal oscillator after reset |
| stable_pri | input | 1 | Primary oscillator stable |
| stable_sec | input | 1 | Secondary oscillator stable |
| stable_int | input | 1 | Internal oscillator stable |
| sleep_req | input | 1 | Sleep request strobe |
| rd_data | output | 8 | Register read value |
| active_src | output | 3 | One-hot active source {internal, secondary, primary} |
| sec_run | output | 1 | Secondary oscillator is active |
| busy | output | 1 | Handover pending |
| enter_idle | output | 1 | One-cycle idle-mode indication |
| enter_sleep | output | 1 | One-cycle sleep-mode indication |

## Verification
The bench builds the block with SETTLE_CYCLES = 3, so each handover finishes in a few cycles. This keeps a full sweep affordable: both values of each configuration input, every select code, and the secondary enable both low and high, each from a fresh reset. With this short window, an off-by-one in the handover count shows up as an early or late change that the bench samples on exact cycles. The same holds for the restart after an unstable cycle and the restart caused by a mid-handover write.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    typedef enum logic [1:0] {
        SEL_DEF = 2'b00,
        SEL_SEC = 2'b01,
        SEL_PRI = 2'b10,
        SEL_INT = 2'b11
    } sel_code_e;

    typedef logic [2:0] src_oh_t;

    localparam src_oh_t SRC_PRI = 3'b001;
    localparam src_oh_t SRC_SEC = 3'b010;
    localparam src_oh_t SRC_INT = 3'b100;

    typedef struct packed {
        logic      idle_en;
        sel_code_e sel;
    } ctrl_t;

    function automatic src_oh_t decode_sel(sel_code_e code, logic pri_default);
        case (code)
            SEL_SEC: return SRC_SEC;
            SEL_PRI: return SRC_PRI;
            SEL_INT: return SRC_INT;
            default: return pri_default ? SRC_PRI : SRC_INT;
        endcase
    endfunction

    function automatic logic [7:0] pack_reg(ctrl_t c, logic status);
        return {c.idle_en, 3'b000, status, 1'b0, c.sel};
    endfunction

endpackage

// File: rtl/clksel_regs.sv
module clksel_regs
    import clksel_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic [7:0] wr_data,
    input  logic      sec_osc_en,
    output ctrl_t     ctrl,
    output logic      sel_accept,
    output sel_code_e new_sel
);

    assign new_sel    = sel_code_e'(wr_data[1:0]);
    assign sel_accept = wr_en && !(new_sel == SEL_SEC && !sec_osc_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.idle_en <= 1'b0;
            ctrl.sel     <= SEL_DEF;
        end else if (wr_en) begin
            ctrl.idle_en <= wr_data[7];
            if (sel_accept) ctrl.sel <= new_sel;
        end
    end

    a_r3_sec_drop: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[1:0] == 2'b01 && !sec_osc_en) |=> $stable(ctrl.sel))
        else $error("R3: secondary select taken while disabled");

endmodule

// File: rtl/clksel_switch.sv
module clksel_switch
    import clksel_pkg::*;
#(
    parameter int SETTLE_CYCLES = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cfg_two_speed,
    input  src_oh_t reset_src,
    input  logic    start,
    input  src_oh_t start_src,
    input  logic    start_def,
    input  src_oh_t stable,
    output src_oh_t active,
    output logic    busy,
    output logic    status
);

    localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    src_oh_t          tgt;
    logic             tgt_def;
    logic [CNT_W-1:0] cnt;
    logic             tgt_ok;

    assign tgt_ok = |(tgt & stable);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= cfg_two_speed ? SRC_INT : reset_src;
            busy    <= cfg_two_speed;
            tgt     <= reset_src;
            tgt_def <= 1'b1;
            status  <= !cfg_two_speed;
            cnt     <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            tgt     <= start_src;
            tgt_def <= start_def;
            cnt     <= '0;
        end else if (busy) begin
            if (!tgt_ok) begin
                cnt <= '0;
            end else if (cnt == LAST) begin
                active <= tgt;
                status <= tgt_def;
                busy   <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    a_r7_unstable_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !tgt_ok && !start) |=> (busy && $stable(active)))
        else $error("R7: handover completed on unstable target");

endmodule

// File: rtl/clksel_pwr.sv
module clksel_pwr (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic idle_en,
    output logic enter_idle,
    output logic enter_sleep
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enter_idle  <= 1'b0;
            enter_sleep <= 1'b0;
        end else begin
            enter_idle  <= sleep_req && idle_en;
            enter_sleep <= sleep_req && !idle_en;
        end
    end

endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
    import clksel_pkg::*;
#(
    parameter int SETTLE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       sec_osc_en,
    input  logic       cfg_pri_default,
    input  logic       cfg_two_speed,
    input  logic       stable_pri,
    input  logic       stable_sec,
    input  logic       stable_int,
    input  logic       sleep_req,
    output logic [7:0] rd_data,
    output logic [2:0] active_src,
    output logic       sec_run,
    output logic       busy,
    output logic       enter_idle,
    output logic       enter_sleep
);

    ctrl_t     ctrl;
    logic      sel_accept;
    sel_code_e new_sel;
    logic      start;
    logic      status;
    src_oh_t   active;

    clksel_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .sec_osc_en (sec_osc_en),
        .ctrl       (ctrl),
        .sel_accept (sel_accept),
        .new_sel    (new_sel)
    );

    assign start = sel_accept && (new_sel != ctrl.sel || busy);

    clksel_switch #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_switch (
        .clk           (clk),
        .rst           (rst),
        .cfg_two_speed (cfg_two_speed),
        .reset_src     (decode_sel(SEL_DEF, cfg_pri_default)),
        .start         (start),
        .start_src     (decode_sel(new_sel, cfg_pri_default)),
        .start_def     (new_sel == SEL_DEF),
        .stable        ({stable_int, stable_sec, stable_pri}),
        .active        (active),
        .busy          (busy),
        .status        (status)
    );

    clksel_pwr u_pwr (
        .clk         (clk),
        .rst         (rst),
        .sleep_req   (sleep_req),
        .idle_en     (ctrl.idle_en),
        .enter_idle  (enter_idle),
        .enter_sleep (enter_sleep)
    );

    assign active_src = active;
    assign sec_run    = (active == SRC_SEC);
    assign rd_data    = pack_reg(ctrl, status);

    a_r12_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(active_src) == 1)
        else $error("R12: active source not one-hot");

    a_r12_change_on_done: assert property (@(posedge clk) disable iff (rst)
        (active_src != $past(active_src)) |-> $fell(busy))
        else $error("R12: source changed outside handover completion");

    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(sec_run && rd_data[3]))
        else $error("R10: run flag and status bit both set");

    a_r11_one_mode: assert property (@(posedge clk) disable iff (rst)
        !(enter_idle && enter_sleep))
        else $error("R11: idle and sleep both signalled");

    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[6:4] == 3'b000 && rd_data[2] == 1'b0)
        else $error("R4: unimplemented bits nonzero");

endmodule

// File: tb/test_clk_src_ctrl.sv
module test_clk_src_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sec_osc_en = 1'b0;
    logic       cfg_pri_default = 1'b0;
    logic       cfg_two_speed = 1'b0;
    logic       stable_pri = 1'b1;
    logic       stable_sec = 1'b1;
    logic       stable_int = 1'b1;
    logic       sleep_req = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] active_src;
    logic       sec_run, busy, enter_idle, enter_sleep;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [1:0] m_sel;
    logic       m_idle;
    logic       m_status;
    logic [2:0] m_act;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_src_ctrl #(.SETTLE_CYCLES(N)) i_clk_src_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .sec_osc_en(sec_osc_en), .cfg_pri_default(cfg_pri_default),
        .cfg_two_speed(cfg_two_speed), .stable_pri(stable_pri),
        .stable_sec(stable_sec), .stable_int(stable_int),
        .sleep_req(sleep_req), .rd_data(rd_data), .active_src(active_src),
        .sec_run(sec_run), .busy(busy), .enter_idle(enter_idle),
        .enter_sleep(enter_sleep)
    );

    function automatic logic [2:0] exp_src(logic [1:0] code, logic pri_def);
        case (code)
            2'b11: return 3'b100;
            2'b10: return 3'b001;
            2'b01: return 3'b010;
            default: return pri_def ? 3'b001 : 3'b100;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_state(string req);
        check({req, " rd_data"}, rd_data, {m_idle, 3'b000, m_status, 1'b0, m_sel});
        check({req, " active"}, active_src, m_act);
        check({req, " sec_run"}, sec_run, m_act == 3'b010);
    endtask

    task automatic do_reset(logic pri_def, logic ts);
        @(negedge clk);
        cfg_pri_default = pri_def;
        cfg_two_speed = ts;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_sel = 2'b00; m_idle = 1'b0; m_status = !ts;
        m_act = ts ? 3'b100 : exp_src(2'b00, pri_def);
        check_state("R5 reset");
        check("R5 reset busy", busy, ts);
        if (ts) begin
            repeat (N-1) @(negedge clk);
            check("R5 two-speed hold", active_src, 3'b100);
            @(negedge clk);
            m_act = exp_src(2'b00, pri_def);
            m_status = 1'b1;
            check_state("R5 two-speed done");
            check("R5 busy done", busy, 1'b0);
        end
    endtask

    task automatic write_reg(logic [1:0] code, logic idle);
        wr_en = 1'b1;
        wr_data = {idle, 3'b111, 1'b1, 1'b1, code};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // sweep: configuration x sec enable x select code
        for (int pd = 0; pd < 2; pd++) begin
            for (int ts = 0; ts < 2; ts++) begin
                for (int se = 0; se < 2; se++) begin
                    do_reset(pd[0], ts[0]);
                    sec_osc_en = se[0];
                    for (int rep = 0; rep < 2; rep++) begin
                        for (int c = 3; c >= 0; c--) begin
                            logic [1:0] code = c[1:0];
                            logic acc = !(code == 2'b01 && !se[0]);
                            logic trans = acc && (code != m_sel);
                            logic idl = code[0] ^ se[0] ^ rep[0];
                            write_reg(code, idl);
                            m_idle = idl;
                            if (acc) m_sel = code;
                            check("R4 rd after write", rd_data,
                                  {m_idle, 3'b000, m_status, 1'b0, m_sel});
                            if (trans) begin
                                check("R6 busy raised", busy, 1'b1);
                                repeat (N-1) @(negedge clk);
                                check("R6 old source held", active_src, m_act);
                                @(negedge clk);
                                m_act = exp_src(code, pd[0]);
                                m_status = (code == 2'b00);
                                check_state("R1 R2 R9 handover");
                                check("R6 busy fell", busy, 1'b0);
                            end else begin
                                check(acc ? "R6 same code no handover" : "R3 dropped busy",
                                      busy, 1'b0);
                                @(negedge clk);
                                check_state(acc ? "R6 same code" : "R3 dropped");
                            end
                        end
                    end
                end
            end
        end

        // R7: unstable target restarts the count
        do_reset(1'b1, 1'b0);
        sec_osc_en = 1'b1;
        stable_int = 1'b0;
        write_reg(2'b11, 1'b0);
        m_sel = 2'b11;
        repeat (6) @(negedge clk);
        check("R7 waiting busy", busy, 1'b1);
        check("R7 waiting active", active_src, 3'b001);
        stable_int = 1'b1;
        repeat (N-1) @(negedge clk);
        stable_int = 1'b0;
        @(negedge clk);
        stable_int = 1'b1;
        repeat (N-1) @(negedge clk);
        check("R7 restarted hold", active_src, 3'b001);
        @(negedge clk);
        m_act = 3'b100; m_status = 1'b0;
        check_state("R7 completes");
        check("R7 busy fell", busy, 1'b0);

        // R8: write during pending handover
        write_reg(2'b10, 1'b0);
        write_reg(2'b01, 1'b0);
        m_sel = 2'b01;
        repeat (N-1) @(negedge clk);
        check("R8 restart hold", active_src, 3'b100);
        check("R8 busy", busy, 1'b1);
        @(negedge clk);
        m_act = 3'b010; m_status = 1'b0;
        check_state("R8 new target");
        check("R10 sec_run", sec_run, 1'b1);

        // R11: idle vs sleep decision
        write_reg(2'b01, 1'b1);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        check("R11 idle pulse", enter_idle, 1'b1);
        check("R11 no sleep", enter_sleep, 1'b0);
        @(negedge clk);
        check("R11 idle one cycle", enter_idle, 1'b0);
        write_reg(2'b01, 1'b0);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        check("R11 sleep pulse", enter_sleep, 1'b1);
        check("R11 no idle", enter_idle, 1'b0);
        @(negedge clk);
        check("R11 sleep one cycle", enter_sleep, 1'b0);

        // R3: idle bit still stored on dropped write
        sec_osc_en = 1'b0;
        write_reg(2'b11, 1'b0);
        m_sel = 2'b11; m_idle = 1'b0;
        repeat (N) @(negedge clk);
        m_act = 3'b100;
        write_reg(2'b01, 1'b1);
        m_idle = 1'b1;
        @(negedge clk);
        check_state("R3 idle kept sel dropped");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule